// File: doc/BRIEF.md
# DDR Read-Capture FIFO Pointer Controller

This block receives read data from a DDR memory and carries it into the internal quarter-phase clock domain (`clk90`). Each byte-lane group has its own delayed data strobe. Every group owns two small capture queues. One queue is written on the rising edge of the group's strobe and the other on the falling edge. Writes happen only while a burst-window enable is high. Each queue has a 16-entry store addressed by a 4-bit Gray-coded pointer.

The write pointers pass into `clk90` through two flip-flop stages. There each one is compared with a single shared Gray read pointer. When no queue in any group is empty, the block fetches one entry from every queue in the same cycle. It loads a 64-bit user word and raises a one-cycle valid strobe. The rising-edge data fills the upper half of the word and the falling-edge data fills the lower half. The word register keeps its last value between fetches.

Top module: `ddr_rdcap_ptr_ctrl`

## Requirements
- R1: While `rst90_n` is low at a `clk90` edge, `user_word` becomes 0 and `data_vld` becomes 0.
- R2: Data on `dq_in` at a rising strobe edge inside the burst window appears in `user_word[63:32]`. Group g's nibble `dq_in[4g+3:4g]` lands at bits `32+4g+3:32+4g`, so the highest group is most significant.
- R3: Data on `dq_in` at the falling strobe edge of the same pair appears in `user_word[31:0]`, with group g's nibble at bits `4g+3:4g`.
- R4: A burst of N rising/falling pairs yields exactly N `data_vld` pulses. The words arrive in write order, with no duplicate and no missing word.
- R5: Strobe edges that occur while `cap_en` is low write nothing, and no `data_vld` pulse results from them.
- R6: In any `clk90` cycle without a `data_vld` pulse, `user_word` holds its previous value.
- R7: Every write pointer and the read pointer change by exactly one bit per advance (Gray code). This includes the wrap from the last entry back to the first, which a burst longer than 16 pairs exercises.
- R8: The read pointer advances only in a cycle that produces a `data_vld` pulse. All queues are read at that single pointer.
- R9: After a reset of both the strobe domain (`rst_dqs_n` low across strobe edges) and the `clk90` domain, all pointers return to entry 0. A following burst delivers exactly its own words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk90 | input | 1 | Internal clock that reads the queues and produces the user word |
| rst90_n | input | 1 | Synchronous active-low reset for the `clk90` domain |
| rst_dqs_n | input | 1 | Active-low reset, synchronous to both strobe edges, for the write pointers |
| dqs_dly | input | 8 | Delayed data strobe, one per group |
| cap_en | input | 1 | Burst-window write enable, sampled on both strobe edges |
| dq_in | input | 32 | Read data from memory, 4 bits per group |
| data_vld | output | 1 | One-cycle strobe marking a new `user_word` |
| user_word | output | 64 | Assembled word: rising-edge data high, falling-edge data low |

## Verification
On every cycle, the assertions check three things. The read pointer and all sixteen write pointers move by a single bit per step. The read pointer moves only in cycles that produce a valid word. The output word stays stable between valid strobes and comes out of reset at zero. Other behaviours are visible only through the bench's scenarios. These are the placement of each group's rising and falling nibble, the ordering and count of words across bursts of different lengths (including one that wraps the 16-entry store), the silence of strobes outside the burst window, and a clean restart after both domains are reset.

// File: rtl/ddr_rdcap_pkg.sv
// Package: shared choices for the read-capture path.
// Assumes: nothing beyond standard SystemVerilog.
package ddr_rdcap_pkg;
    // Which strobe edge clocks a capture lane.
    typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} cap_edge_e;
    // Flop stages used to move a Gray pointer into clk90.
    parameter int unsigned PTR_SYNC_STAGES = 2;
endpackage

// File: rtl/ddr_rdcap_gray_ctr.sv
// Module: Gray-code pointer. Keeps a binary shadow count and a registered
// Gray value, so each advance flips exactly one output bit.
// Assumes: rst_n is synchronous to clk.
module ddr_rdcap_gray_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] gray
);
    logic [W-1:0] bin_q;
    logic [W-1:0] bin_nxt;

    assign bin_nxt = bin_q + 1'b1;

    // Step both the binary and the Gray copy on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q <= '0;
            gray  <= '0;
        end else if (adv) begin
            bin_q <= bin_nxt;
            gray  <= bin_nxt ^ (bin_nxt >> 1);
        end
    end
endmodule

// File: rtl/ddr_rdcap_sync.sv
// Module: multi-flop synchronizer for a Gray-coded bus.
// Assumes: the input changes by at most one bit at a time.
module ddr_rdcap_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Build the flop chain, with the first stage fed by d.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: capture the foreign-domain value.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Later stages: let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ddr_rdcap_ram.sv
// Module: small store written on one clock and read asynchronously.
// Assumes: reads of an address happen only after its write is visible
// through the pointer synchronizer.
module ddr_rdcap_ram #(
    parameter int AW = 4,
    parameter int W  = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Write one entry on the strobe edge when enabled.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ddr_rdcap_lane.sv
// Module: one capture lane. It holds a write pointer clocked by the chosen
// strobe edge, its store, the pointer synchronizer into clk90, and the empty
// compare against the shared read pointer.
// Assumes: rst_dqs_n is seen on the chosen strobe edge; rd_ptr is in clk90.
module ddr_rdcap_lane
    import ddr_rdcap_pkg::*;
#(
    parameter cap_edge_e EDGE = EDGE_RISE,
    parameter int        AW   = 4,
    parameter int        NIB  = 4
) (
    input  logic           dqs,
    input  logic           rst_dqs_n,
    input  logic           cap_en,
    input  logic [NIB-1:0] dq_nib,
    input  logic           clk90,
    input  logic           rst90_n,
    input  logic [AW-1:0]  rd_ptr,
    output logic           empty,
    output logic [NIB-1:0] rd_nib,
    output logic [AW-1:0]  wr_ptr
);
    logic          wclk;
    logic [AW-1:0] wr_ptr_sync;

    // The edge parameter selects the clock polarity.
    if (EDGE == EDGE_RISE) begin : g_rise
        assign wclk = dqs;
    end else begin : g_fall
        assign wclk = ~dqs;
    end

    ddr_rdcap_gray_ctr #(.W(AW)) u_wptr (
        .clk   (wclk),
        .rst_n (rst_dqs_n),
        .adv   (cap_en),
        .gray  (wr_ptr)
    );

    ddr_rdcap_ram #(.AW(AW), .W(NIB)) u_store (
        .wclk  (wclk),
        .we    (cap_en),
        .waddr (wr_ptr),
        .wdata (dq_nib),
        .raddr (rd_ptr),
        .rdata (rd_nib)
    );

    ddr_rdcap_sync #(.W(AW), .STAGES(PTR_SYNC_STAGES)) u_wsync (
        .clk   (clk90),
        .rst_n (rst90_n),
        .d     (wr_ptr),
        .q     (wr_ptr_sync)
    );

    assign empty = (wr_ptr_sync == rd_ptr);
endmodule

// File: rtl/ddr_rdcap_ptr_ctrl.sv
// Module: top of the read-capture path. It builds one rising-edge and one
// falling-edge lane per strobe group and a shared Gray read pointer. It
// fetches from all lanes when none is empty and registers the 64-bit word.
// Assumes: the reader drains at least as fast as the strobe writes, so a
// lane never gets 16 entries ahead of the read pointer.
module ddr_rdcap_ptr_ctrl
    import ddr_rdcap_pkg::*;
#(
    parameter int GROUPS = 8,
    parameter int NIB    = 4,
    parameter int AW     = 4
) (
    input  logic                       clk90,
    input  logic                       rst90_n,
    input  logic                       rst_dqs_n,
    input  logic [GROUPS-1:0]          dqs_dly,
    input  logic                       cap_en,
    input  logic [GROUPS*NIB-1:0]      dq_in,
    output logic                       data_vld,
    output logic [2*GROUPS*NIB-1:0]    user_word
);
    localparam int DW = GROUPS * NIB;

    logic [GROUPS-1:0]    empty_rise;
    logic [GROUPS-1:0]    empty_fall;
    logic [DW-1:0]        rise_word;
    logic [DW-1:0]        fall_word;
    logic [GROUPS*AW-1:0] wp_rise_all;
    logic [GROUPS*AW-1:0] wp_fall_all;
    logic [AW-1:0]        rd_ptr_g;
    logic                 fetch;

    // Two lanes per group, each taking that group's nibble.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        ddr_rdcap_lane #(.EDGE(EDGE_RISE), .AW(AW), .NIB(NIB)) u_rise (
            .dqs       (dqs_dly[g]),
            .rst_dqs_n (rst_dqs_n),
            .cap_en    (cap_en),
            .dq_nib    (dq_in[g*NIB +: NIB]),
            .clk90     (clk90),
            .rst90_n   (rst90_n),
            .rd_ptr    (rd_ptr_g),
            .empty     (empty_rise[g]),
            .rd_nib    (rise_word[g*NIB +: NIB]),
            .wr_ptr    (wp_rise_all[g*AW +: AW])
        );
        ddr_rdcap_lane #(.EDGE(EDGE_FALL), .AW(AW), .NIB(NIB)) u_fall (
            .dqs       (dqs_dly[g]),
            .rst_dqs_n (rst_dqs_n),
            .cap_en    (cap_en),
            .dq_nib    (dq_in[g*NIB +: NIB]),
            .clk90     (clk90),
            .rst90_n   (rst90_n),
            .rd_ptr    (rd_ptr_g),
            .empty     (empty_fall[g]),
            .rd_nib    (fall_word[g*NIB +: NIB]),
            .wr_ptr    (wp_fall_all[g*AW +: AW])
        );
    end

    // Read only when every lane holds data, so all lanes move together.
    assign fetch = ~(|empty_rise) & ~(|empty_fall);

    ddr_rdcap_gray_ctr #(.W(AW)) u_rptr (
        .clk   (clk90),
        .rst_n (rst90_n),
        .adv   (fetch),
        .gray  (rd_ptr_g)
    );

    // Output register: load on fetch, clear on reset, hold otherwise.
    always_ff @(posedge clk90) begin
        if (!rst90_n) begin
            user_word <= '0;
            data_vld  <= 1'b0;
        end else begin
            data_vld <= fetch;
            if (fetch) user_word <= {rise_word, fall_word};
        end
    end
endmodule

// File: rtl/ddr_rdcap_chk.sv
// Module: assertion checker bound to ddr_rdcap_ptr_ctrl.
// Assumes: it is attached only through the bind at the end of this file.
module ddr_rdcap_chk #(
    parameter int GROUPS = 8,
    parameter int AW     = 4,
    parameter int UW     = 64
) (
    input logic                 clk90,
    input logic                 rst90_n,
    input logic                 rst_dqs_n,
    input logic [GROUPS-1:0]    dqs_dly,
    input logic                 data_vld,
    input logic [UW-1:0]        user_word,
    input logic [AW-1:0]        rd_ptr,
    input logic [GROUPS*AW-1:0] wp_rise,
    input logic [GROUPS*AW-1:0] wp_fall
);
    logic seen90;

    // Marks cycles whose previous sample was already out of reset.
    always_ff @(posedge clk90) seen90 <= rst90_n;

    // R1: the first cycle after reset shows a cleared word and no strobe.
    a_r1_reset_clear: assert property (@(posedge clk90) disable iff (!rst90_n)
        $rose(rst90_n) |-> (user_word == '0 && !data_vld));

    // R6: no valid strobe means the word did not move.
    a_r6_hold_word: assert property (@(posedge clk90) disable iff (!rst90_n)
        (seen90 && !data_vld) |-> $stable(user_word));

    // R7: the read pointer moves by one bit.
    a_r7_rdptr_gray: assert property (@(posedge clk90) disable iff (!rst90_n)
        (seen90 && rd_ptr != $past(rd_ptr)) |-> $countones(rd_ptr ^ $past(rd_ptr)) == 1);

    // R8: the read pointer moves only alongside a valid word.
    a_r8_rdptr_with_vld: assert property (@(posedge clk90) disable iff (!rst90_n)
        (seen90 && rd_ptr != $past(rd_ptr)) |-> data_vld);

    for (genvar g = 0; g < GROUPS; g++) begin : g_wchk
        logic seen_r;
        logic seen_f;

        // Per-edge marks of a settled previous sample.
        always_ff @(posedge dqs_dly[g]) seen_r <= rst_dqs_n;
        always_ff @(negedge dqs_dly[g]) seen_f <= rst_dqs_n;

        // R7: rising-edge write pointer steps in Gray code.
        a_r7_wptr_rise_gray: assert property (@(posedge dqs_dly[g]) disable iff (!rst_dqs_n)
            (seen_r && wp_rise[g*AW +: AW] != $past(wp_rise[g*AW +: AW]))
            |-> $countones(wp_rise[g*AW +: AW] ^ $past(wp_rise[g*AW +: AW])) == 1);

        // R7: falling-edge write pointer steps in Gray code.
        a_r7_wptr_fall_gray: assert property (@(negedge dqs_dly[g]) disable iff (!rst_dqs_n)
            (seen_f && wp_fall[g*AW +: AW] != $past(wp_fall[g*AW +: AW]))
            |-> $countones(wp_fall[g*AW +: AW] ^ $past(wp_fall[g*AW +: AW])) == 1);
    end
endmodule

bind ddr_rdcap_ptr_ctrl ddr_rdcap_chk #(
    .GROUPS (GROUPS),
    .AW     (AW),
    .UW     (2*GROUPS*NIB)
) u_chk (
    .clk90     (clk90),
    .rst90_n   (rst90_n),
    .rst_dqs_n (rst_dqs_n),
    .dqs_dly   (dqs_dly),
    .data_vld  (data_vld),
    .user_word (user_word),
    .rd_ptr    (rd_ptr_g),
    .wp_rise   (wp_rise_all),
    .wp_fall   (wp_fall_all)
);

// File: tb/ddr_rdcap_ptr_ctrl_tb.sv
// Bench: a scoreboard. The burst driver queues the expected words and a
// monitor on the falling clk90 edge pops and compares them.
module ddr_rdcap_ptr_ctrl_tb;
    localparam int G   = 8;
    localparam int NIB = 4;
    localparam int AW  = 4;
    localparam int DW  = G * NIB;
    localparam int UW  = 2 * DW;

    logic          clk90 = 1'b0;
    logic          rst90_n;
    logic          rst_dqs_n;
    logic [G-1:0]  dqs_dly;
    logic          cap_en;
    logic [DW-1:0] dq_in;
    logic          data_vld;
    logic [UW-1:0] user_word;

    int            tests   = 0;
    int            fails   = 0;
    int            got_cnt = 0;
    bit            armed   = 1'b0;
    bit            done    = 1'b0;
    logic [UW-1:0] exp_q [$];
    logic [UW-1:0] last_word;
    logic [UW-1:0] e_word;

    always #10 clk90 = ~clk90;

    ddr_rdcap_ptr_ctrl #(.GROUPS(G), .NIB(NIB), .AW(AW)) u_dut (
        .clk90     (clk90),
        .rst90_n   (rst90_n),
        .rst_dqs_n (rst_dqs_n),
        .dqs_dly   (dqs_dly),
        .cap_en    (cap_en),
        .dq_in     (dq_in),
        .data_vld  (data_vld),
        .user_word (user_word)
    );

    task automatic check(input bit ok, input string req,
                         input logic [UW-1:0] act, input logic [UW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One strobe period: rising data, rising edge, falling data, falling edge.
    task automatic strobe_pair(input logic [DW-1:0] r, input logic [DW-1:0] f);
        dq_in = r;
        #5 dqs_dly = '1;
        #5 dq_in = f;
        #5 dqs_dly = '0;
        #5;
    endtask

    // Driver: write n pairs inside the window and queue the expected words.
    task automatic burst(input int n, input logic [DW-1:0] base);
        @(posedge clk90);
        #3 cap_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            logic [DW-1:0] r;
            logic [DW-1:0] f;
            r = base + DW'(i) * 32'h1111_1111;
            f = ~base - DW'(i) * 32'h0101_0101;
            strobe_pair(r, f);
            exp_q.push_back({r, f});
        end
        cap_en = 1'b0;
        dq_in  = '0;
    endtask

    task automatic drain_check(input int n, input string req);
        repeat (12) @(posedge clk90);
        @(negedge clk90);
        check(exp_q.size() == 0, {req, " words left undelivered"}, UW'(exp_q.size()), '0);
        check(got_cnt == n, {req, " valid word count"}, UW'(got_cnt), UW'(n));
        got_cnt = 0;
    endtask

    // Reset both domains; strobes toggle so the edge-clocked reset lands.
    task automatic do_reset();
        armed     = 1'b0;
        rst90_n   = 1'b0;
        rst_dqs_n = 1'b0;
        cap_en    = 1'b0;
        dq_in     = '0;
        dqs_dly   = '0;
        repeat (3) begin
            @(posedge clk90);
            #8  dqs_dly = '1;
            #10 dqs_dly = '0;
        end
        rst_dqs_n = 1'b1;
        repeat (2) @(posedge clk90);
        @(negedge clk90);
        rst90_n = 1'b1;
        exp_q.delete();
        last_word = '0;
        got_cnt   = 0;
        @(negedge clk90);
        armed = 1'b1;
    endtask

    // Monitor: compare each valid word, and check the hold between words.
    always @(negedge clk90) begin
        if (armed && rst90_n) begin
            if (data_vld) begin
                got_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 extra or duplicate word", user_word, '0);
                end else begin
                    e_word = exp_q.pop_front();
                    check(user_word[UW-1:DW] == e_word[UW-1:DW], "R2 rising half",
                          user_word, e_word);
                    check(user_word[DW-1:0] == e_word[DW-1:0], "R3 falling half",
                          user_word, e_word);
                end
                last_word = user_word;
            end else begin
                check(user_word == last_word, "R6 word held", user_word, last_word);
            end
        end
    end

    initial begin
        do_reset();
        // R1: the cleared state after reset.
        check(user_word == '0, "R1 word after reset", user_word, '0);
        check(!data_vld, "R1 valid after reset", UW'(data_vld), '0);

        // R4 R2 R3: a short burst, then single-pair and nibble-placement bursts.
        burst(4, 32'hA5A5_3C3C);
        drain_check(4, "R4 burst of 4");
        burst(1, 32'h0000_000F);
        drain_check(1, "R4 single pair");
        burst(3, 32'hF000_0000);
        drain_check(3, "R2 top group nibble");

        // R7 R8: a long burst that wraps the 16-entry store in lockstep.
        burst(20, 32'h1234_5678);
        drain_check(20, "R7 R8 wrapped burst");

        // R5: strobes outside the window write nothing.
        for (int i = 0; i < 6; i++) begin
            @(posedge clk90);
            #3 strobe_pair(32'hDEAD_0000 + DW'(i), 32'hBEEF_0000 + DW'(i));
        end
        drain_check(0, "R5 strobes with window closed");
        check(user_word == last_word, "R5 word unchanged", user_word, last_word);

        // R9: reset both domains with pointers away from zero, then restart.
        do_reset();
        check(user_word == '0, "R9 word after second reset", user_word, '0);
        burst(7, 32'h5A5A_0F0F);
        drain_check(7, "R9 burst after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk90);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule